// File: doc/BRIEF.md
# Power Stage Fault Sequencer

This block is the digital supervisor of a synchronous buck power stage. It takes digitised comparator flags (logic-supply good, input-supply good, high-side overcurrent, switch-node over-voltage, and the two over-temperature thresholds), the present state of the high-side (GH) and low-side (GL) gate commands, and a flag that says the controller's PWM line sits in its tri-state window. From these it produces the stage enable, a veto that forces the high-side gate off, a current-monitor fault flag, a temperature-monitor fault flag, an active-low fault output and the overcurrent-protection arm signal.

Start-up is gated by a power-on delay counted in clock cycles. Overcurrent is a soft fault: the controller acknowledges it by holding PWM in tri-state, and the fault clears after a short hold time. A shorted high-side switch is a hard fault that stays latched until the logic supply goes away. Over-temperature uses two thresholds for hysteresis and only reports; it never touches the gates.

Top module: `ps_fault_seq`

## Requirements
- R1: `stageEn` goes high only after the synchronised logic-supply flag has been high for `POR_CYCLES` consecutive clock cycles; with `SYNC_STAGES`=2, a rise on `vccOkIn` makes `stageEn` high `POR_CYCLES`+2 clock edges later. A drop of that flag forces `stageEn` low on the next edge and the count restarts from zero.
- R2: `ocpArm` is high exactly when both synchronised supply flags (`vccOkIn`, `vinOkIn`) are high.
- R3: When `stageEn` and `ocpArm` are high and the synchronised overcurrent flag is seen while `ghOn` is high, an overcurrent fault is latched on the next edge: `ghVeto` and `imonFault` go high and `faultN` goes low.
- R4: A latched overcurrent fault clears on the clock edge `ACK_CYCLES`+1 edges after the synchronised tri-state flag is first seen high, provided the flag stays high throughout; a tri-state pulse that drops early restarts the wait, and without acknowledge the fault holds indefinitely.
- R5: When `stageEn` is high and the synchronised switch-node over-voltage flag is seen while `glOn` is high, a short fault is latched that drives `ghVeto` and `imonFault` high and `faultN` low; the tri-state acknowledge does not clear it.
- R6: The temperature fault sets on the synchronised rising flag (`otHotIn`) and clears only on the synchronised cool flag (`otCoolIn`); it drives `tmonFault` high and `faultN` low and leaves `ghVeto` unchanged.
- R7: `faultN` is low whenever any fault is active, `stageEn` is low, or the synchronised input-supply flag is low; otherwise it is high.
- R8: Every comparator input passes through `SYNC_STAGES` flip-flops before use, so an input change is acted on no earlier than `SYNC_STAGES`+1 edges later.
- R9: An overcurrent flag is ignored while `ghOn` is low or while the input supply is absent (`ocpArm` low).
- R10: A switch-node over-voltage flag is ignored while `glOn` is low.
- R11: Loss of the logic-supply flag clears the overcurrent, short and temperature faults; after a fresh power-on delay the outputs show no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vccOkIn | input | 1 | Logic supply above power-on threshold (asynchronous) |
| vinOkIn | input | 1 | Input supply above power-on threshold (asynchronous) |
| ocTripIn | input | 1 | High-side overcurrent comparator (asynchronous) |
| swOverIn | input | 1 | Switch-node over-voltage comparator (asynchronous) |
| otHotIn | input | 1 | Temperature above the set threshold (asynchronous) |
| otCoolIn | input | 1 | Temperature below the clear threshold (asynchronous) |
| triStateIn | input | 1 | PWM input inside its tri-state window (asynchronous) |
| ghOn | input | 1 | High-side gate command is on |
| glOn | input | 1 | Low-side gate command is on |
| stageEn | output | 1 | Stage enable after power-on delay |
| ghVeto | output | 1 | Forces the high-side gate off |
| imonFault | output | 1 | Current-monitor fault flag |
| tmonFault | output | 1 | Temperature-monitor fault flag |
| faultN | output | 1 | Active-low fault output (open-drain style) |
| ocpArm | output | 1 | Overcurrent protection armed |

## Verification
The bench aims at the exact edge on which the power-on delay completes and on which the overcurrent acknowledge timer expires; a counter off by one would show `stageEn` or the fault clearing a cycle early or late. It interrupts the logic supply partway through the delay and cuts a tri-state pulse short, which catches a timer that keeps its count instead of restarting. It sends the acknowledge to a short fault, which a design that mixes up the two current faults would wrongly clear, and it parks the temperature between its thresholds, where a design without hysteresis would drop the fault. Overcurrent with GH off or with the input supply missing, and over-voltage with GL off, check the gating qualifiers.

// File: rtl/ps_fault_pkg.sv
package ps_fault_pkg;

  // Comparator flags, raw or synchronised
  typedef struct packed {
    logic vcc;
    logic vin;
    logic oc;
    logic swOv;
    logic otHot;
    logic otCool;
    logic triSt;
  } compFlags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic porRun;
    logic ackRun;
  } seqStrobe_t;

endpackage

// File: rtl/ps_fault_dp.sv
module ps_fault_dp
  import ps_fault_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POR_CYCLES  = 12500,
  parameter int ACK_CYCLES  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  compFlags_t rawFlags,
  input  seqStrobe_t strobe,
  output compFlags_t syncFlags,
  output logic       porDone,
  output logic       ackDone
);

  localparam int PorW = $clog2(POR_CYCLES + 1);
  localparam int AckW = $clog2(ACK_CYCLES + 1);
  localparam logic [PorW-1:0] PorLast = PorW'(POR_CYCLES);
  localparam logic [AckW-1:0] AckLast = AckW'(ACK_CYCLES);

  compFlags_t syncChain [SYNC_STAGES];

  // Synchroniser chain for all comparator flags
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncChain[0] <= '0;
          else        syncChain[0] <= rawFlags;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncChain[s] <= '0;
          else        syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  assign syncFlags = syncChain[SYNC_STAGES-1];

  logic [PorW-1:0] porCnt;
  logic [AckW-1:0] ackCnt;

  // Power-on delay counter: runs while supply good, saturates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                porCnt <= '0;
    else if (!strobe.porRun)   porCnt <= '0;
    else if (porCnt != PorLast) porCnt <= porCnt + 1'b1;
  end

  // Acknowledge hold counter: runs while fault is acknowledged
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ackCnt <= '0;
    else if (!strobe.ackRun)   ackCnt <= '0;
    else if (ackCnt != AckLast) ackCnt <= ackCnt + 1'b1;
  end

  assign porDone = (porCnt == PorLast);
  assign ackDone = (ackCnt == AckLast);

endmodule

// File: rtl/ps_fault_ctrl.sv
module ps_fault_ctrl
  import ps_fault_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  compFlags_t syncFlags,
  input  logic       porDone,
  input  logic       ackDone,
  input  logic       ghOn,
  input  logic       glOn,
  output seqStrobe_t strobe,
  output logic       stageEn,
  output logic       ocpArm,
  output logic       ocFault,
  output logic       shortFault,
  output logic       otFault
);

  assign stageEn = porDone;
  assign ocpArm  = syncFlags.vcc & syncFlags.vin;

  assign strobe.porRun = syncFlags.vcc;
  assign strobe.ackRun = ocFault & syncFlags.triSt;

  logic ocSet, shortSet;
  assign ocSet    = stageEn & ocpArm & syncFlags.oc & ghOn;
  assign shortSet = stageEn & syncFlags.swOv & glOn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocFault    <= 1'b0;
      shortFault <= 1'b0;
      otFault    <= 1'b0;
    end else if (!syncFlags.vcc) begin
      // logic-supply loss is the power-on reset for all faults
      ocFault    <= 1'b0;
      shortFault <= 1'b0;
      otFault    <= 1'b0;
    end else begin
      if (ocSet)        ocFault <= 1'b1;
      else if (ackDone) ocFault <= 1'b0;

      if (shortSet) shortFault <= 1'b1;

      if (stageEn && syncFlags.otHot) otFault <= 1'b1;
      else if (syncFlags.otCool)      otFault <= 1'b0;
    end
  end

endmodule

// File: rtl/ps_fault_seq.sv
module ps_fault_seq
  import ps_fault_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POR_CYCLES  = 12500,
  parameter int ACK_CYCLES  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vccOkIn,
  input  logic vinOkIn,
  input  logic ocTripIn,
  input  logic swOverIn,
  input  logic otHotIn,
  input  logic otCoolIn,
  input  logic triStateIn,
  input  logic ghOn,
  input  logic glOn,
  output logic stageEn,
  output logic ghVeto,
  output logic imonFault,
  output logic tmonFault,
  output logic faultN,
  output logic ocpArm
);

  compFlags_t rawFlags, syncFlags;
  seqStrobe_t strobe;
  logic porDone, ackDone;
  logic ocFault, shortFault, otFault;

  assign rawFlags = '{vcc: vccOkIn, vin: vinOkIn, oc: ocTripIn, swOv: swOverIn,
                      otHot: otHotIn, otCool: otCoolIn, triSt: triStateIn};

  ps_fault_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .POR_CYCLES (POR_CYCLES),
    .ACK_CYCLES (ACK_CYCLES)
  ) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rawFlags (rawFlags),
    .strobe   (strobe),
    .syncFlags(syncFlags),
    .porDone  (porDone),
    .ackDone  (ackDone)
  );

  ps_fault_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .syncFlags (syncFlags),
    .porDone   (porDone),
    .ackDone   (ackDone),
    .ghOn      (ghOn),
    .glOn      (glOn),
    .strobe    (strobe),
    .stageEn   (stageEn),
    .ocpArm    (ocpArm),
    .ocFault   (ocFault),
    .shortFault(shortFault),
    .otFault   (otFault)
  );

  assign ghVeto    = ocFault | shortFault;
  assign imonFault = ocFault | shortFault;
  assign tmonFault = otFault;
  assign faultN    = stageEn & syncFlags.vin & ~(ocFault | shortFault | otFault);

endmodule

// File: rtl/ps_fault_checker.sv
module ps_fault_checker (
  input logic clk,
  input logic rst_n,
  input logic vccSync,
  input logic vinSync,
  input logic triSync,
  input logic coolSync,
  input logic stageEn,
  input logic ghVeto,
  input logic tmonFault,
  input logic faultN,
  input logic ocFault,
  input logic shortFault
);

  // R1: supply loss removes enable on the next edge
  a_r1_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !vccSync |=> !stageEn);

  // R3: an active high-side veto always shows on the fault output
  a_r3_veto_reports: assert property (@(posedge clk) disable iff (!rst_n)
    ghVeto |-> !faultN);

  // R4: without acknowledge the overcurrent fault holds
  a_r4_oc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ocFault && !triSync && vccSync) |=> ocFault);

  // R5: short fault stays latched while the logic supply is present
  a_r5_short_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (shortFault && vccSync) |=> shortFault);

  // R6: temperature fault holds until the cool flag
  a_r6_ot_hysteresis: assert property (@(posedge clk) disable iff (!rst_n)
    (tmonFault && !coolSync && vccSync) |=> tmonFault);

  // R7: missing input supply pulls the fault output low
  a_r7_vin_low_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !vinSync |-> !faultN);

  // R11: supply loss clears every fault on the next edge
  a_r11_supply_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !vccSync |=> (!ocFault && !shortFault && !tmonFault));

endmodule

bind ps_fault_seq ps_fault_checker uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vccSync   (syncFlags.vcc),
  .vinSync   (syncFlags.vin),
  .triSync   (syncFlags.triSt),
  .coolSync  (syncFlags.otCool),
  .stageEn   (stageEn),
  .ghVeto    (ghVeto),
  .tmonFault (tmonFault),
  .faultN    (faultN),
  .ocFault   (ocFault),
  .shortFault(shortFault)
);

// File: tb/ps_fault_seq_test.sv
`timescale 1ns/1ps
module ps_fault_seq_test;

  localparam int SYNC = 2;
  localparam int POR  = 8;
  localparam int ACK  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vccOkIn = 0, vinOkIn = 0, ocTripIn = 0, swOverIn = 0;
  logic otHotIn = 0, otCoolIn = 1, triStateIn = 0, ghOn = 0, glOn = 0;
  logic stageEn, ghVeto, imonFault, tmonFault, faultN, ocpArm;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ps_fault_seq #(.SYNC_STAGES(SYNC), .POR_CYCLES(POR), .ACK_CYCLES(ACK)) uut (
    .clk(clk), .rst_n(rst_n),
    .vccOkIn(vccOkIn), .vinOkIn(vinOkIn), .ocTripIn(ocTripIn), .swOverIn(swOverIn),
    .otHotIn(otHotIn), .otCoolIn(otCoolIn), .triStateIn(triStateIn),
    .ghOn(ghOn), .glOn(glOn),
    .stageEn(stageEn), .ghVeto(ghVeto), .imonFault(imonFault),
    .tmonFault(tmonFault), .faultN(faultN), .ocpArm(ocpArm)
  );

  // advance n edges, then settle 1 ns past the edge
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // reset state
    chk("R1", "reset stageEn", stageEn, 1'b0);
    chk("R7", "reset faultN", faultN, 1'b0);
    chk("R3", "reset ghVeto", ghVeto, 1'b0);
    chk("R6", "reset tmonFault", tmonFault, 1'b0);
    chk("R2", "reset ocpArm", ocpArm, 1'b0);

    // R1 power-on delay exact edge
    vccOkIn = 1; vinOkIn = 1;
    tick(POR + 1);
    chk("R1", "enable one edge early", stageEn, 1'b0);
    tick(1);
    chk("R1", "enable on time", stageEn, 1'b1);
    chk("R7", "faultN released", faultN, 1'b1);
    chk("R2", "armed with both supplies", ocpArm, 1'b1);

    // R1 drop and restart
    vccOkIn = 0;
    tick(3);
    chk("R1", "enable removed on drop", stageEn, 1'b0);
    chk("R7", "faultN low during por", faultN, 1'b0);
    chk("R2", "disarmed without vcc", ocpArm, 1'b0);
    vccOkIn = 1;
    tick(4);
    vccOkIn = 0;
    tick(2);
    vccOkIn = 1;
    tick(POR + 1);
    chk("R1", "restart count early", stageEn, 1'b0);
    tick(1);
    chk("R1", "restart count done", stageEn, 1'b1);

    // R2 / R7 input supply
    vinOkIn = 0;
    tick(2);
    chk("R2", "disarmed without vin", ocpArm, 1'b0);
    chk("R7", "faultN low without vin", faultN, 1'b0);
    chk("R1", "enable kept without vin", stageEn, 1'b1);
    // R9 overcurrent ignored while disarmed
    ghOn = 1; ocTripIn = 1;
    tick(4);
    chk("R9", "oc ignored when disarmed", imonFault, 1'b0);
    ocTripIn = 0; vinOkIn = 1;
    tick(3);
    chk("R2", "rearmed", ocpArm, 1'b1);
    // R9 overcurrent ignored with GH off
    ghOn = 0; ocTripIn = 1;
    tick(4);
    chk("R9", "oc ignored with gh off", imonFault, 1'b0);
    chk("R9", "faultN unaffected", faultN, 1'b1);
    ocTripIn = 0;
    tick(3);

    // R3 / R8 overcurrent latency
    ghOn = 1; ocTripIn = 1;
    tick(SYNC);
    chk("R8", "oc not yet seen", imonFault, 1'b0);
    tick(1);
    chk("R3", "oc imonFault", imonFault, 1'b1);
    chk("R3", "oc ghVeto", ghVeto, 1'b1);
    chk("R3", "oc faultN", faultN, 1'b0);
    ocTripIn = 0; ghOn = 0;
    tick(10);
    chk("R4", "oc holds without ack", imonFault, 1'b1);

    // R4 short tri-state pulse restarts wait
    triStateIn = 1;
    tick(1);
    triStateIn = 0;
    tick(ACK + 4);
    chk("R4", "short ack ignored", imonFault, 1'b1);
    // R4 full acknowledge
    triStateIn = 1;
    tick(ACK + 2);
    chk("R4", "ack one edge early", imonFault, 1'b1);
    tick(1);
    chk("R4", "ack clears fault", imonFault, 1'b0);
    chk("R4", "veto released", ghVeto, 1'b0);
    chk("R4", "faultN released", faultN, 1'b1);
    triStateIn = 0;
    tick(3);

    // R6 over-temperature hysteresis
    otHotIn = 1; otCoolIn = 0;
    tick(SYNC + 1);
    chk("R6", "ot set", tmonFault, 1'b1);
    chk("R6", "ot faultN", faultN, 1'b0);
    chk("R6", "ot no veto", ghVeto, 1'b0);
    otHotIn = 0;
    tick(5);
    chk("R6", "ot holds between thresholds", tmonFault, 1'b1);
    otCoolIn = 1;
    tick(SYNC);
    chk("R6", "ot cool not yet seen", tmonFault, 1'b0 ^ 1'b1);
    tick(1);
    chk("R6", "ot cleared", tmonFault, 1'b0);
    chk("R6", "faultN after ot", faultN, 1'b1);

    // R10 over-voltage ignored with GL off
    glOn = 0; swOverIn = 1;
    tick(4);
    chk("R10", "ov ignored with gl off", imonFault, 1'b0);
    swOverIn = 0;
    tick(3);

    // R5 shorted high side latch
    glOn = 1; swOverIn = 1;
    tick(SYNC + 1);
    chk("R5", "short imonFault", imonFault, 1'b1);
    chk("R5", "short ghVeto", ghVeto, 1'b1);
    chk("R5", "short faultN", faultN, 1'b0);
    swOverIn = 0; glOn = 0; triStateIn = 1;
    tick(ACK + 6);
    chk("R5", "short survives ack", imonFault, 1'b1);
    triStateIn = 0;

    // R11 supply loss clears all faults
    otHotIn = 1; otCoolIn = 0;
    tick(SYNC + 1);
    chk("R6", "ot set with short", tmonFault, 1'b1);
    otHotIn = 0;
    vccOkIn = 0;
    tick(3);
    chk("R11", "short cleared", ghVeto, 1'b0);
    chk("R11", "imon cleared", imonFault, 1'b0);
    chk("R11", "ot cleared", tmonFault, 1'b0);
    otCoolIn = 1;
    vccOkIn = 1;
    tick(POR + 2);
    chk("R11", "enable after repower", stageEn, 1'b1);
    chk("R11", "no fault after repower", faultN, 1'b1);

    finished = 1;
    summary();
    $finish;
  end

endmodule